// File: doc/BRIEF.md
# Oversampling Baud Tick Generator with Selectable Prescaler

This block derives the 16x oversampling tick used by a UART's transmit and receive paths from a fixed reference clock. The clock is taken as 7.3728 MHz. Software programs a 16-bit divisor as two byte-wide latches, a low byte and a high byte. The low 15 bits of the divisor set the division ratio. The top bit does not divide. It selects the speed range instead.

The reference clock first passes a prescaler stage. That stage normally divides by 4, so a divisor of 1 gives 115200 baud. When divisor bit 15 is set and the external high-speed enable is also asserted, the prescaler is bypassed and the divisor counter runs at the full reference rate. Divisors 0x8001 through 0x8004 then give 460800, 230400, 153600 and 115200 baud. Writing either latch byte restarts the prescaler and the counter, so a new rate takes effect without waiting for the old period to finish.

Top module: `baud_tick_gen`

## Requirements
- R1: A write with `wr_sel`=0 stores `wr_data` in the low byte and a write with `wr_sel`=1 stores it in the high byte. `rd_data` shows the low byte when `rd_sel`=0 and the high byte when `rd_sel`=1. Both read back exactly as written, including high-byte bit 7 (divisor bit 15).
- R2: A write to either byte reloads the prescaler and the counter on the following clock edge, and `tick_16x` is low in the cycle after that edge. With no further writes, the first tick appears after the (1 + P)th clock edge following the write edge, where P is the tick period.
- R3: With divisor bit 15 at 0, the tick period is P = 4 × D reference cycles, where D is the low 15 divisor bits.
- R4: With divisor bit 15 at 1 and `hs_enable` at 0, the prescaler stays at divide-by-4 and P = 4 × D.
- R5: With divisor bit 15 at 1 and `hs_enable` at 1, the prescaler is bypassed and P = D. Only in this mode can ticks occur on consecutive cycles.
- R6: Only the low 15 bits set D, so the largest ratio is 32767. With 0xFFFF and high speed on, P is 32767.
- R7: A low 15-bit value of 0 acts as D = 1, so the tick never stalls.
- R8: Whenever P > 1, `tick_16x` is high for exactly one cycle per period.
- R9: Reset (synchronous, active low) clears both bytes to 0 and holds `tick_16x` low. After release, the first tick follows the 4th clock edge and ticks then repeat every 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (7.3728 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Latch write strobe, one cycle per byte |
| wr_sel | input | 1 | Byte select for writes: 0 low, 1 high |
| wr_data | input | 8 | Byte to write |
| hs_enable | input | 1 | High-speed mode permission from mode configuration |
| rd_sel | input | 1 | Byte select for readback: 0 low, 1 high |
| rd_data | output | 8 | Selected latch byte |
| tick_16x | output | 1 | One-cycle pulse at 16 × baud rate |

## Verification
The assertions assume `hs_enable` changes only while no tick decision depends on it. They also assume writes come as single-cycle strobes with a defined `wr_sel`. The stimulus sets `hs_enable` before it writes the divisor and leaves it alone until the next write. Each byte write is strobed for exactly one cycle. Random divisors keep the low 15 bits small so that periods stay short, and directed cases cover the zero divisor and the 32767 maximum.

// File: rtl/bdiv_pkg.sv
// Shared definitions for the baud tick generator.
// Assumes byte-wide latch access; the divisor word is two bytes.
package bdiv_pkg;
    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;
endpackage

// File: rtl/bdiv_latch.sv
// Divisor latch pair: holds the low and high divisor bytes, serves
// readback and raises a one-cycle reload strobe after any write.
// Assumes wr_en is a single-cycle strobe per byte.
module bdiv_latch #(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DIV_W-1:0]  div_word,
    output logic              reload
);
    import bdiv_pkg::*;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              reload_q;

    // Capture written bytes into the selected latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            if (byte_sel_e'(wr_sel) == SEL_HI) hi_q <= wr_data;
            else                               lo_q <= wr_data;
        end
    end

    // Delay the write strobe by one edge so the reload sees the new word.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= 1'b0;
        else        reload_q <= wr_en;
    end

    // Readback mux and divisor word assembly.
    always_comb begin
        rd_data  = (byte_sel_e'(rd_sel) == SEL_HI) ? hi_q : lo_q;
        div_word = {hi_q, lo_q};
        reload   = reload_q;
    end
endmodule

// File: rtl/bdiv_prescale.sv
// Reference-clock prescaler: emits a count enable every PRE_DIV cycles,
// or every cycle when bypass is asserted. Restarts its phase on reload.
// Assumes PRE_DIV is a power of two or 1.
module bdiv_prescale #(
    parameter int PRE_DIV = 4,
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic bypass,
    output logic pre_en
);
    generate
        if (PRE_DIV > 1) begin : g_div
            logic [PRE_W-1:0] phase_q;

            // Advance the prescaler phase; reset or reload restarts it.
            always_ff @(posedge clk) begin
                if (!rst_n || reload) phase_q <= '0;
                else                  phase_q <= phase_q + PRE_W'(1);
            end

            // Enable on the last phase, or always when bypassed.
            always_comb begin
                pre_en = bypass || (phase_q == PRE_W'(PRE_DIV - 1));
            end
        end else begin : g_none
            logic unused_in;
            // No prescaling configured: enable every cycle.
            always_comb begin
                unused_in = rst_n ^ reload ^ bypass ^ clk;
                pre_en    = 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/bdiv_counter.sv
// Divisor down-counter: counts prescaler enables from the effective
// ratio to 1, then pulses the tick and reloads. A zero ratio acts as 1.
// Assumes ratio is stable except when reload is asserted.
module bdiv_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             pre_en,
    input  logic [CNT_W-1:0] ratio,
    output logic [CNT_W-1:0] cnt_val,
    output logic             tick
);
    logic [CNT_W-1:0] eff_ratio;
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    // Clamp a zero ratio to one so the count always terminates.
    always_comb begin
        eff_ratio = (ratio == '0) ? CNT_W'(1) : ratio;
    end

    // Count down on enable; tick and reload at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            cnt_q  <= rst_n ? eff_ratio : CNT_W'(1);
            tick_q <= 1'b0;
        end else if (pre_en) begin
            if (cnt_q <= CNT_W'(1)) begin
                cnt_q  <= eff_ratio;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q - CNT_W'(1);
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    // Drive outputs from registered state.
    always_comb begin
        cnt_val = cnt_q;
        tick    = tick_q;
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Baud tick generator top: divisor latches, prescaler and counter.
// The top divisor bit, together with hs_enable, bypasses the prescaler;
// the remaining bits set the ratio. Clock is the fixed reference clock.
module baud_tick_gen #(
    parameter int BYTE_W  = 8,
    parameter int PRE_DIV = 4,
    localparam int DIV_W  = 2 * BYTE_W,
    localparam int CNT_W  = DIV_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              hs_enable,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              tick_16x
);
    logic [DIV_W-1:0] div_word;
    logic             reload;
    logic             bypass;
    logic             pre_en;
    logic [CNT_W-1:0] cnt_val;

    bdiv_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .div_word (div_word),
        .reload   (reload)
    );

    // Prescaler bypass needs both the select bit and the mode permission.
    always_comb begin
        bypass = div_word[DIV_W-1] && hs_enable;
    end

    bdiv_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (reload),
        .bypass (bypass),
        .pre_en (pre_en)
    );

    bdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload),
        .pre_en  (pre_en),
        .ratio   (div_word[CNT_W-1:0]),
        .cnt_val (cnt_val),
        .tick    (tick_16x)
    );
endmodule

// File: rtl/bdiv_checker.sv
// Property checker for baud_tick_gen, attached by bind.
// Assumes hs_enable is held steady around tick decisions.
module bdiv_checker #(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W,
    localparam int CNT_W = DIV_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              hs_enable,
    input logic              tick_16x,
    input logic [DIV_W-1:0]  div_word,
    input logic [CNT_W-1:0]  cnt_val
);
    // R1: low byte captures the written data
    p_lo_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (div_word[BYTE_W-1:0] == $past(wr_data)));

    // R1: high byte captures the written data, bit 15 included
    p_hi_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (div_word[DIV_W-1:BYTE_W] == $past(wr_data)));

    // R2: the cycle after the reload edge carries no tick
    p_reload_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ##2 !tick_16x);

    // R5: back-to-back ticks only with the prescaler bypassed
    p_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_16x && $past(tick_16x)) |-> $past(hs_enable && div_word[DIV_W-1]));

    // R7: the counter never holds zero, so it cannot stall
    p_cnt_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_val != '0);
endmodule

bind baud_tick_gen bdiv_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .hs_enable (hs_enable),
    .tick_16x  (tick_16x),
    .div_word  (div_word),
    .cnt_val   (cnt_val)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       hs_enable = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       tick_16x;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    baud_tick_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .hs_enable(hs_enable), .rd_sel(rd_sel),
        .rd_data(rd_data), .tick_16x(tick_16x)
    );

    always #5 clk = ~clk;

    // Expected tick period from divisor word and mode permission.
    function automatic int exp_period(input logic [15:0] dv, input logic hs);
        int d;
        d = int'(dv[14:0]);
        if (d == 0) d = 1;
        return (dv[15] && hs) ? d : 4 * d;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write both bytes, then measure latency, pulse width and period.
    task automatic run_case(input string req, input logic [15:0] dv,
                            input logic hs, input bit with_period);
        int p, k, m;
        hs_enable = hs;
        p = exp_period(dv, hs);
        write_byte(1'b0, dv[7:0]);
        write_byte(1'b1, dv[15:8]);
        k = 0;
        do begin
            @(posedge clk); @(negedge clk); k++;
        end while (!tick_16x && k < 140000);
        check({req, " R2 first-tick latency"}, k, 1 + p);
        if (with_period) begin
            m = 0;
            do begin
                @(posedge clk); @(negedge clk); m++;
                if (m == 1 && p > 1) check({req, " R8 one-cycle pulse"}, int'(tick_16x), 0);
            end while (!tick_16x && m < 140000);
            check({req, " period"}, m, p);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 tick in reset", int'(tick_16x), 0);
        rd_sel = 1'b0; #1 check("R9 low byte reset", int'(rd_data), 0);
        rd_sel = 1'b1; #1 check("R9 high byte reset", int'(rd_data), 0);
        rst_n = 1'b1;
        k = 0;
        do begin @(posedge clk); @(negedge clk); k++; end while (!tick_16x && k < 100);
        check("R9 first tick after reset", k, 4);

        // R1: readback including bit 15
        write_byte(1'b0, 8'h5A);
        write_byte(1'b1, 8'hC3);
        rd_sel = 1'b0; #1 check("R1 low readback", int'(rd_data), 8'h5A);
        rd_sel = 1'b1; #1 check("R1 high readback", int'(rd_data), 8'hC3);

        // Directed corner cases
        run_case("R3 prescaled d=3", 16'h0003, 1'b1, 1'b1);
        run_case("R4 bit15 without hs", 16'h8005, 1'b0, 1'b1);
        run_case("R5 hs 0x8001", 16'h8001, 1'b1, 1'b1);
        run_case("R5 hs 0x8004", 16'h8004, 1'b1, 1'b1);
        run_case("R7 zero prescaled", 16'h0000, 1'b0, 1'b1);
        run_case("R7 zero bypass", 16'h8000, 1'b1, 1'b1);
        run_case("R6 max ratio", 16'hFFFF, 1'b1, 1'b0);

        // Constrained random divisors, small ratios
        for (int i = 0; i < 12; i++) begin
            logic [15:0] dv;
            logic        hs;
            dv = {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, 15'($urandom_range(40, 0))};
            hs = ($urandom_range(1, 0) == 1);
            run_case("R3/R5 random", dv, hs, 1'b1);
            rd_sel = 1'b1; #1 check("R1 random high readback", int'(rd_data), int'(dv[15:8]));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule